// File: doc/BRIEF.md
# Character Display Output Port

This block is the output register pair through which a 16-bit processor hands characters, one at a time, to a display device. Two bus addresses are decoded: a status word and a data word. The processor polls the status word (or waits for the interrupt) until the ready flag is one. It then writes a character to the data word. The port latches the low byte and gives the device a one-cycle valid strobe. It then holds the ready flag low until the device answers with a one-cycle done pulse.

While the port is busy, writes to the data word are discarded without any trace. Software controls an interrupt-enable bit held in the status word. The interrupt request is a level that stays high while the port is ready and interrupts are enabled. The port holds exactly one character and does no buffering beyond that.

Top module: `char_display_port`

## Requirements
- R1: After reset the ready flag is one, the interrupt enable is zero, `irq` is low and `chr_vld` is low.
- R2: A read (`rd_en` high) at address 0xFE04 returns the ready flag in bit 15, the interrupt enable in bit 14 and zero in bits 13..0. A read at any other address, and any cycle with `rd_en` low, returns zero. `rdata` is combinational.
- R3: A write at 0xFE06 while ready is one is accepted. On the next cycle `chr_vld` is high for exactly one cycle, `chr` equals bits 7..0 of the written word, and ready is zero.
- R4: A write at 0xFE06 while ready is zero is discarded. It causes no `chr_vld` pulse and leaves `chr` unchanged.
- R5: A `dev_done` pulse while ready is zero sets ready to one on the next cycle.
- R6: A write at 0xFE04 sets the interrupt enable to bit 14 of the written word. It leaves the ready flag unchanged, and its other bits have no effect.
- R7: `irq` is high exactly when ready and the interrupt enable are both one.
- R8: Writes to any address other than 0xFE04 and 0xFE06 change neither the ready flag, the interrupt enable, `chr` nor `chr_vld`.
- R9: When `dev_done` and a data write arrive in the same cycle while ready is zero, the write is discarded and ready becomes one.
- R10: When `dev_done` and a data write arrive in the same cycle while ready is one, the write is accepted and ready becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Bus read data |
| chr | output | 8 | Character presented to the device |
| chr_vld | output | 1 | One-cycle strobe for each accepted character |
| dev_done | input | 1 | Device completion pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Two events can fall in the same cycle: a completion pulse from the device and a data write from the processor. The bench provokes both orderings. In one, the pulse ends a busy period in the very cycle a stale write arrives, and that write must be dropped while ready still rises (R9). In the other, a stray pulse comes while the port is idle, alongside a legal write, and the write must win (R10). Each outcome is judged by the presence or absence of the valid strobe, the held character and the status word read back on the next cycle.

// File: rtl/char_display_port.sv
module char_display_port #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] STATUS_ADDR = 16'hFE04,
  parameter logic [AW-1:0] DATA_ADDR   = 16'hFE06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] chr,
  output logic          chr_vld,
  input  logic          dev_done,
  output logic          irq
);
  localparam int IE_BIT = DW - 2;

  logic ready_q, ie_q, vld_q;
  logic [CW-1:0] chr_q;

  logic hit_stat, hit_data, accept;
  assign hit_stat = (addr == STATUS_ADDR);
  assign hit_data = (addr == DATA_ADDR);
  assign accept   = wr_en && hit_data && ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      ie_q    <= 1'b0;
      vld_q   <= 1'b0;
      chr_q   <= '0;
    end else begin
      vld_q <= accept;
      if (accept) begin
        chr_q   <= wdata[CW-1:0];
        ready_q <= 1'b0;
      end else if (dev_done) begin
        ready_q <= 1'b1;
      end
      if (wr_en && hit_stat) ie_q <= wdata[IE_BIT];
    end
  end

  assign rdata   = (rd_en && hit_stat) ? {ready_q, ie_q, {(DW-2){1'b0}}} : '0;
  assign chr     = chr_q;
  assign chr_vld = vld_q;
  assign irq     = ready_q & ie_q;
endmodule

// File: rtl/char_display_port_chk.sv
module char_display_port_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] STATUS_ADDR = 16'hFE04,
  parameter logic [AW-1:0] DATA_ADDR   = 16'hFE06
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic          dev_done,
  input logic [CW-1:0] chr,
  input logic          chr_vld,
  input logic          irq,
  input logic          ready,
  input logic          ie
);
  a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DATA_ADDR && ready) |=> (chr_vld && !ready && chr == $past(wdata[CW-1:0])));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    chr_vld |=> !chr_vld);

  a_r4_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DATA_ADDR && !ready) |=> (!chr_vld && $stable(chr)));

  a_r5_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !ready) |=> ready);

  a_r6_ie_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == STATUS_ADDR && !dev_done) |=> (ie == $past(wdata[DW-2]) && ready == $past(ready)));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wr_en && addr == STATUS_ADDR && wdata[DW-2]) || $past(dev_done)));
endmodule

bind char_display_port char_display_port_chk #(
  .AW(AW), .DW(DW), .CW(CW), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .dev_done(dev_done), .chr(chr), .chr_vld(chr_vld), .irq(irq),
  .ready(ready_q), .ie(ie_q)
);

// File: tb/test_char_display_port.sv
module test_char_display_port;
  localparam logic [15:0] ST = 16'hFE04;
  localparam logic [15:0] DT = 16'hFE06;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, dev_done = 1'b0;
  logic [15:0] rdata;
  logic [7:0] chr;
  logic chr_vld, irq;

  int nchk = 0, nfail = 0;
  bit done_flag = 0;

  logic e_ready = 1'b1, e_ie = 1'b0, e_vld = 1'b0;
  logic [7:0] e_chr = '0;

  always #4 clk = ~clk;

  char_display_port i_char_display_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .chr(chr), .chr_vld(chr_vld),
    .dev_done(dev_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                      input logic [15:0] d, input logic dn, input string tag);
    logic acc;
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d; dev_done = dn;
    #1;
    chk({tag, " R2 rdata"}, rdata, (rd && a == ST) ? {e_ready, e_ie, 14'b0} : 16'h0);
    acc = wr && a == DT && e_ready;
    e_vld = acc;
    if (acc) begin
      e_chr = d[7:0];
      e_ready = 1'b0;
    end else if (dn) e_ready = 1'b1;
    if (wr && a == ST) e_ie = d[14];
    @(posedge clk);
    #1;
    chk({tag, " R3 R4 chr_vld"}, {15'b0, chr_vld}, {15'b0, e_vld});
    chk({tag, " R3 R4 chr"}, {8'b0, chr}, {8'b0, e_chr});
    chk({tag, " R7 irq"}, {15'b0, irq}, {15'b0, e_ready & e_ie});
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 16'h0, 16'h0, 1'b0, tag);
  endtask

  task automatic read_status(input string tag);
    step(1'b0, 1'b1, ST, 16'h0, 1'b0, tag);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 chr_vld", {15'b0, chr_vld}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    read_status("R1");

    for (int c = 0; c < 256; c++) begin
      logic [15:0] sw;
      sw = c[0] ? 16'hFFFF : 16'hBFFF;
      step(1'b1, 1'b0, ST, sw, 1'b0, "R6 status write");
      read_status("R6 R7");
      if (c % 16 == 5) begin
        step(1'b1, 1'b0, DT + 16'h1, {8'h00, 8'(c)}, 1'b0, "R8 near data");
        step(1'b1, 1'b0, ST ^ 16'h0100, 16'h0000, 1'b0, "R8 alias status");
        step(1'b1, 1'b0, 16'h0000, 16'hFFFF, 1'b0, "R8 low addr");
        read_status("R8");
      end
      if (c % 7 == 3)
        step(1'b1, 1'b0, DT, {8'hA5, 8'(c)}, 1'b1, "R10 done while ready");
      else
        step(1'b1, 1'b0, DT, {8'hA5, 8'(c)}, 1'b0, "R3 accept");
      read_status("R3 busy");
      for (int g = 0; g < c % 4; g++)
        step(1'b1, 1'b0, DT, {8'h00, 8'(~c)}, 1'b0, "R4 busy write");
      if (c % 3 == 0)
        step(1'b1, 1'b0, DT, {8'h00, 8'(c ^ 8'h5A)}, 1'b1, "R9 done with write");
      else
        step(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, "R5 done");
      read_status("R5 R9");
      idle("idle");
    end

    @(negedge clk); rst_n = 1'b0;
    e_ready = 1'b1; e_ie = 1'b0; e_vld = 1'b0; e_chr = '0;
    @(posedge clk); @(negedge clk); rst_n = 1'b1;
    read_status("R1 re-reset");
    finish_run();
  end
endmodule